// File: doc/BRIEF.md
# MSI Doorbell Interrupt Aggregator

The block gathers message-signalled interrupts from endpoints into one level interrupt for the host CPU. An endpoint posts a vector number to a doorbell. That vector's sticky pending bit is set in a 256-entry status array. Each vector also has an enable bit. The single `irq` output is high while any vector is both pending and enabled. A vector that arrives while masked keeps its pending bit and fires as soon as it is unmasked.

Inbound doorbells use a valid/ready stream port. `db_ready` is tied high, so the port never applies back-pressure, and every cycle with `db_valid` high is one accepted doorbell. The host sees a plain 32-bit register bus with combinational read data. Through it the host can:
- ring the doorbell itself;
- read and acknowledge pending words (write-one-to-clear);
- program enable words;
- drive a one-bit select that steers a shared window to configuration-space access.

Top module: `msi_doorbell_agg`

## Requirements
- R1: A cycle with `db_valid` high and `db_vector` below 256 sets pending bit v = `db_vector`; `db_ready` is always 1.
- R2: A bus write to byte offset 0x7C with data v below 256 sets pending bit v in the same way as R1.
- R3: A doorbell value of 256 or above, on either path, changes no pending bit.
- R4: Pending bit v reads as bit v%32 of the word at offset 0x80 + 4*(v/32). A bus write to such a word clears only the bits written as 1.
- R5: Enable bit v is bit v%32 of the read/write word at offset 0xA0 + 4*(v/32). All enables are 0 after reset.
- R6: `irq` is 1 exactly when some vector has both its pending and enable bits set.
- R7: Pending bits latch while the vector is masked, and setting the enable later raises `irq`.
- R8: If a doorbell and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R9: Bit 0 of the word at offset 0x48 is read/write and drives `cfg_sel`. It resets to 0, and its other bits read as 0.
- R10: Reads of unmapped offsets, including the doorbell at 0x7C, return 0. Writes to unmapped offsets change nothing.
- R11: After reset, all pending bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Inbound doorbell valid |
| db_ready | output | 1 | Always 1; doorbells are never stalled |
| db_vector | input | 32 | Doorbell data: vector number |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cfg_sel | output | 1 | Configuration-access select |
| irq | output | 1 | Aggregated level interrupt |

## Verification
The bench builds the block with its default of 256 vectors, which gives eight 32-bit banks. With that size the last status word abuts the first enable word at 0xA0. Vectors 255 and 256 then sit on either side of the range limit, and 31/32 sit on either side of a bank edge. Random traffic mixes both doorbell paths, partial acknowledges and enable rewrites across all eight banks. Directed steps cover the same-cycle set and clear, and doorbells arriving while the vector is masked.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int WORD_W = 32;
  localparam logic [7:0] OFF_CFGSEL = 8'h48;
  localparam logic [7:0] OFF_BELL   = 8'h7C;
  localparam logic [7:0] OFF_PEND   = 8'h80;
  localparam logic [7:0] OFF_ENA    = 8'hA0;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CFGSEL,
    RK_BELL,
    RK_PEND,
    RK_ENA
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] bank;
  } reg_hit_t;
endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANK = 8
) (
  input  logic [7:0] addr,
  output reg_hit_t   hit
);
  localparam int SPAN = 4 * NUM_BANK;

  logic [7:0] waddr;
  int         rel;

  always_comb begin
    waddr    = {addr[7:2], 2'b00};
    hit.kind = RK_NONE;
    hit.bank = '0;
    rel      = 0;
    if (waddr == OFF_CFGSEL) begin
      hit.kind = RK_CFGSEL;
    end else if (waddr == OFF_BELL) begin
      hit.kind = RK_BELL;
    end else if (int'(waddr) >= int'(OFF_PEND) && int'(waddr) < int'(OFF_PEND) + SPAN) begin
      hit.kind = RK_PEND;
      rel      = (int'(waddr) - int'(OFF_PEND)) / 4;
      hit.bank = rel[7:0];
    end else if (int'(waddr) >= int'(OFF_ENA) && int'(waddr) < int'(OFF_ENA) + SPAN) begin
      hit.kind = RK_ENA;
      rel      = (int'(waddr) - int'(OFF_ENA)) / 4;
      hit.bank = rel[7:0];
    end
  end
endmodule

// File: rtl/msi_vec_bank.sv
module msi_vec_bank
  import msi_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_mask,
  input  logic              ack_we,
  input  logic              ena_we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] pend,
  output logic [WORD_W-1:0] ena,
  output logic              bank_irq
);
  logic [WORD_W-1:0] ack_mask;

  assign ack_mask = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      ena  <= '0;
    end else begin
      pend <= (pend & ~ack_mask) | set_mask;
      if (ena_we) ena <= wdata;
    end
  end

  assign bank_irq = |(pend & ena);

  assert_set_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(set_mask)) == $past(set_mask)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((pend & $past(wdata & ~set_mask)) == '0));

  assert_ena_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_we |=> $stable(ena));
endmodule

// File: rtl/msi_doorbell_agg.sv
module msi_doorbell_agg
  import msi_agg_pkg::*;
#(
  parameter int NUM_VEC = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        db_valid,
  output logic        db_ready,
  input  logic [31:0] db_vector,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cfg_sel,
  output logic        irq
);
  localparam int NUM_BANK = NUM_VEC / WORD_W;
  localparam int BANK_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;

  reg_hit_t          hit;
  logic              wr;
  logic              port_ok;
  logic              bus_ok;
  logic [WORD_W-1:0] pend_w [NUM_BANK];
  logic [WORD_W-1:0] ena_w  [NUM_BANK];
  logic [NUM_BANK-1:0] irq_b;
  logic [NUM_VEC-1:0]  pend_flat;

  msi_reg_decode #(.NUM_BANK(NUM_BANK)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  assign db_ready = 1'b1;
  assign wr       = bus_sel && bus_we;
  assign port_ok  = db_valid && (db_vector < NUM_VEC);
  assign bus_ok   = wr && (hit.kind == RK_BELL) && (bus_wdata < NUM_VEC);

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic [WORD_W-1:0] set_m;
    logic              sel_b;

    assign sel_b = (hit.bank == 8'(b));
    assign set_m = ((port_ok && (db_vector >> 5) == 32'(b)) ? (32'b1 << db_vector[4:0]) : '0)
                 | ((bus_ok  && (bus_wdata >> 5) == 32'(b)) ? (32'b1 << bus_wdata[4:0]) : '0);

    msi_vec_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_m),
      .ack_we   (wr && hit.kind == RK_PEND && sel_b),
      .ena_we   (wr && hit.kind == RK_ENA && sel_b),
      .wdata    (bus_wdata),
      .pend     (pend_w[b]),
      .ena      (ena_w[b]),
      .bank_irq (irq_b[b])
    );

    assign pend_flat[b*WORD_W +: WORD_W] = pend_w[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          cfg_sel <= 1'b0;
    else if (wr && hit.kind == RK_CFGSEL) cfg_sel <= bus_wdata[0];
  end

  assign irq = |irq_b;

  always_comb begin
    bus_rdata = '0;
    case (hit.kind)
      RK_CFGSEL: bus_rdata = {31'b0, cfg_sel};
      RK_PEND:   bus_rdata = pend_w[hit.bank[BANK_W-1:0]];
      RK_ENA:    bus_rdata = ena_w[hit.bank[BANK_W-1:0]];
      default:   bus_rdata = '0;
    endcase
  end

  assert_range_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!db_valid || db_vector >= NUM_VEC) && !(bus_sel && bus_we) |=>
      ((pend_flat & ~$past(pend_flat)) == '0));

  assert_cfgsel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(cfg_sel));

  assert_quiet_reset_R11: assert property (@(posedge clk)
    !rst_n |=> (pend_flat == '0) && !irq);

  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    db_ready);
endmodule

// File: tb/tb_msi_doorbell_agg.sv
module tb_msi_doorbell_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        db_valid = 0;
  logic        db_ready;
  logic [31:0] db_vector = 0;
  logic        bus_sel = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        cfg_sel;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit m_pend [256];
  bit m_ena  [256];
  bit m_cfg;

  always #5 clk = ~clk;

  msi_doorbell_agg dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word(bit is_ena, int bank);
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) w[i] = is_ena ? m_ena[bank*32+i] : m_pend[bank*32+i];
    return w;
  endfunction

  function automatic logic m_irq();
    for (int i = 0; i < 256; i++) if (m_pend[i] && m_ena[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void m_write(logic [7:0] a, logic [31:0] d);
    if (a == 8'h48) m_cfg = d[0];
    else if (a == 8'h7C) begin
      if (d < 256) m_pend[d] = 1;
    end else if (a >= 8'h80 && a < 8'hA0) begin
      for (int i = 0; i < 32; i++) if (d[i]) m_pend[(a-8'h80)/4*32+i] = 0;
    end else if (a >= 8'hA0 && a < 8'hC0) begin
      for (int i = 0; i < 32; i++) m_ena[(a-8'hA0)/4*32+i] = d[i];
    end
  endfunction

  task automatic ring(logic [31:0] v);
    @(negedge clk); db_valid = 1; db_vector = v;
    @(negedge clk); db_valid = 0;
    if (v < 256) m_pend[v] = 1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    m_write(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    for (int b = 0; b < 8; b++) begin
      rd(8'(8'h80 + 4*b), d); check({tag, " R4 status"}, d, m_word(0, b));
      rd(8'(8'hA0 + 4*b), d); check({tag, " R5 enable"}, d, m_word(1, b));
    end
    rd(8'h48, d); check({tag, " R9 cfg word"}, d, {31'b0, m_cfg});
    check({tag, " R9 cfg_sel"}, {31'b0, cfg_sel}, {31'b0, m_cfg});
    check({tag, " R6 irq"}, {31'b0, irq}, {31'b0, m_irq()});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    m_cfg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 / R5 reset state
    check_all("reset R11");
    check("R1 ready", {31'b0, db_ready}, 32'd1);

    // R1 bank edges via port, masked so R7 holds irq low
    ring(0); ring(31); ring(32); ring(255);
    check_all("R1 port");
    check("R7 masked irq", {31'b0, irq}, 32'd0);
    // R7 unmask fires
    wr(8'hBC, 32'h8000_0000);
    check("R7 unmask irq", {31'b0, irq}, 32'd1);
    // R3 out of range
    ring(256); ring(32'hFFFF_FFFF); wr(8'h7C, 32'd256);
    check_all("R3 range");
    // R2 bus doorbell
    wr(8'h7C, 32'd77);
    check_all("R2 bus bell");
    // R4 partial clear
    wr(8'h80, 32'h0000_0001);
    check_all("R4 w1c");
    // R8 same-cycle set and clear on vector 77 (bank 2 bit 13)
    @(negedge clk);
    db_valid = 1; db_vector = 77;
    bus_sel = 1; bus_we = 1; bus_addr = 8'h88; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    db_valid = 0; bus_sel = 0; bus_we = 0;
    m_write(8'h88, 32'hFFFF_FFFF); m_pend[77] = 1;
    rd(8'h88, d); check("R8 set wins", d, 32'h0000_2000);
    // R9 mux
    wr(8'h48, 32'hFFFF_FFFF);
    check_all("R9 cfg set");
    wr(8'h48, 32'h0);
    check_all("R9 cfg clr");
    // R10 unmapped
    rd(8'h00, d); check("R10 rd 00", d, 0);
    rd(8'h7C, d); check("R10 rd bell", d, 0);
    rd(8'hC0, d); check("R10 rd C0", d, 0);
    wr(8'h04, 32'hFFFF_FFFF); wr(8'hC4, 32'hFFFF_FFFF); wr(8'h4C, 32'h1);
    check_all("R10 wr unmapped");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      int bk;
      op = $urandom_range(0, 4);
      bk = $urandom_range(0, 7);
      case (op)
        0: ring($urandom_range(0, 300));
        1: wr(8'h7C, $urandom_range(0, 300));
        2: wr(8'(8'h80 + 4*bk), $urandom);
        3: wr(8'(8'hA0 + 4*bk), $urandom & $urandom);
        default: wr(8'h48, $urandom);
      endcase
      check("R6 irq random", {31'b0, irq}, {31'b0, m_irq()});
      if (it % 50 == 49) check_all("random R1 R2 R4 R5");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule